// File: doc/BRIEF.md
# Byte/Word ALU With Status Flags

This unit is the data-operation engine of a small 16-bit processor core. Each issued operation takes a 4-bit operation code, a source and a destination operand, the incoming carry and a byte/word select. The unit returns one registered result word, a write-back enable and the four condition flags (negative, zero, carry, overflow) together with a per-flag update mask. It covers binary add and subtract, with and without carry. It also covers packed-decimal add, the bitwise group, the one-bit right shifts, the byte exchange and sign extension.

Operations take effect one clock after `issue` is sampled high. The unit fetches no operands and holds no registers. The surrounding core reads `wr_en` to decide whether the destination is written. It reads `flag_we` to decide which status bits take the new `flag_*` values. Single-operand operations (the shifts, byte exchange and sign extension) work on `dst`. The asynchronous active-low reset is released to the internal registers through a two-stage synchronizer.

Top module: `bw_alu`

## Requirements
- R1: Operation codes are ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, DADD=5, AND=6, BIC=7, BIS=8, XOR=9, BIT=10, MOV=11, RRC=12, RRA=13, SWPB=14 and SXT=15. The arithmetic results are ADD dst+src, ADDC dst+src+carry_in, SUB dst+~src+1, SUBC dst+~src+carry_in and CMP dst+~src+1.
- R2: The bitwise results are AND src&dst, BIT src&dst, BIC ~src&dst, BIS src|dst, XOR src^dst and MOV src.
- R3: DADD adds dst, src and carry_in as packed decimal digits: 2 digits in byte mode and 4 in word mode. The flag C is the decimal carry out of the top active digit, and V is 0.
- R4: RRC shifts dst right by one and puts carry_in into the top active bit. RRA shifts dst right by one and keeps the top active bit. For both, C is the old bit 0 and V is 0.
- R5: SWPB exchanges the two bytes of dst. SXT copies dst bit 7 into bits 15..8. Both ignore byte_sel and always work on the full word.
- R6: In byte mode (byte_sel=1) every operation except SWPB and SXT uses only bits 7..0 of the operands and returns bits 15..8 of the result as zero.
- R7: wr_en is 0 for CMP and BIT and 1 for every other operation.
- R8: N is the top bit of the active width (bit 7 in byte mode, bit 15 otherwise). Z is 1 exactly when the active-width result is zero.
- R9: For ADD, ADDC, SUB, SUBC and CMP, C is the carry out of the active width, so for subtraction C=1 means no borrow. V is 1 on signed overflow.
- R10: flag_we bits are [0]=C, [1]=Z, [2]=N, [3]=V. The mask is 4'hF for the arithmetic group, DADD, AND, BIT, XOR, RRC, RRA and SXT. It is 4'h0 for BIC, BIS, MOV and SWPB, whose flag outputs are all 0. For AND, BIT, XOR and SXT, C equals not Z. V is 0 for AND, BIT and SXT. For XOR, V is set when both operands are negative at the active width.
- R11: out_valid rises exactly one clock after issue is sampled high. While issue is low, result, wr_en, flags and mask hold their values. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Start one operation this cycle |
| op | input | 4 | Operation code (R1 encoding) |
| byte_sel | input | 1 | 1 = byte operation, 0 = word |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand (single-operand input) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registered from the previous issue |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Destination write-back enable |
| flag_we | output | 4 | Flag update mask {V,N,Z,C} |
| flag_v | output | 1 | New overflow flag |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |

## Verification
All state of the unit is the output register, so a wrong next-state value shows at the ports in the very next cycle after the issue. A bad carry chain shows in C or in the decimal digits. A bad width select shows as non-zero upper bits, or as N and Z taken from the wrong bit. The stimulus places carries exactly at the byte and word boundaries, signed overflow in both directions, decimal roll-over at 99 and 9999, and byte-mode operands with upper bits set, so that width leaks are visible. A hold phase and a reset phase show whether the register enables are wrong.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;
  localparam int unsigned OP_W = 4;
  localparam int unsigned FL_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,  OP_DADD = 4'd5,  OP_AND  = 4'd6,  OP_BIC  = 4'd7,
    OP_BIS  = 4'd8,  OP_XOR  = 4'd9,  OP_BIT  = 4'd10, OP_MOV  = 4'd11,
    OP_RRC  = 4'd12, OP_RRA  = 4'd13, OP_SWPB = 4'd14, OP_SXT  = 4'd15
  } alu_op_e;

  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_N = 2;
  localparam int unsigned FL_V = 3;

  localparam logic [FL_W-1:0] FLAGS_ALL  = 4'hF;
  localparam logic [FL_W-1:0] FLAGS_NONE = 4'h0;
endpackage

// File: rtl/bwa_arith.sv
// Binary add/subtract path with carry and signed overflow at byte or word width.
module bwa_arith
  import bw_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic           byte_sel,
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   dst,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout,
  output logic           ovf
);
  localparam int H = W / 2;

  logic         subtract;
  logic         c0;
  logic [W-1:0] addend;
  logic [W:0]   full;
  logic [H:0]   half;

  always_comb begin
    subtract = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
    addend   = subtract ? ~src : src;
    case (op)
      OP_ADD:         c0 = 1'b0;
      OP_SUB, OP_CMP: c0 = 1'b1;
      default:        c0 = cin;
    endcase
    full = {1'b0, dst} + {1'b0, addend} + {{W{1'b0}}, c0};
    half = {1'b0, dst[H-1:0]} + {1'b0, addend[H-1:0]} + {{H{1'b0}}, c0};
    if (byte_sel) begin
      sum  = {{(W-H){1'b0}}, half[H-1:0]};
      cout = half[H];
      ovf  = (dst[H-1] == addend[H-1]) && (half[H-1] != dst[H-1]);
    end else begin
      sum  = full[W-1:0];
      cout = full[W];
      ovf  = (dst[W-1] == addend[W-1]) && (full[W-1] != dst[W-1]);
    end
  end
endmodule

// File: rtl/bwa_bcd.sv
// Packed-decimal adder: one corrected 4-bit digit cell per nibble, rippled carry.
module bwa_bcd #(
  parameter int W = 16
) (
  input  logic           byte_sel,
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   dst,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout
);
  localparam int D  = W / 4;
  localparam int DH = D / 2;
  localparam int H  = W / 2;

  logic [W-1:0] digits;
  logic [4:0]   raw;
  logic         c;
  logic         c_half;

  always_comb begin
    c      = cin;
    c_half = 1'b0;
    digits = '0;
    raw    = '0;
    for (int i = 0; i < D; i++) begin
      raw = {1'b0, dst[4*i +: 4]} + {1'b0, src[4*i +: 4]} + {4'b0000, c};
      if (raw > 5'd9) begin
        digits[4*i +: 4] = raw[3:0] + 4'd6;
        c = 1'b1;
      end else begin
        digits[4*i +: 4] = raw[3:0];
        c = 1'b0;
      end
      if (i == DH - 1) c_half = c;
    end
    if (byte_sel) begin
      sum  = {{(W-H){1'b0}}, digits[H-1:0]};
      cout = c_half;
    end else begin
      sum  = digits;
      cout = c;
    end
  end
endmodule

// File: rtl/bwa_logic.sv
// Bitwise, move, shift, byte-exchange and sign-extend path.
module bwa_logic
  import bw_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic           byte_sel,
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   dst,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           shout
);
  localparam int H = W / 2;

  logic [W-1:0] r;
  logic         word_only;

  always_comb begin
    word_only = (op == OP_SWPB) || (op == OP_SXT);
    shout     = dst[0];
    case (op)
      OP_AND, OP_BIT: r = src & dst;
      OP_BIC:         r = ~src & dst;
      OP_BIS:         r = src | dst;
      OP_XOR:         r = src ^ dst;
      OP_MOV:         r = src;
      OP_RRC:         r = byte_sel ? {{(W-H){1'b0}}, cin, dst[H-1:1]}
                                   : {cin, dst[W-1:1]};
      OP_RRA:         r = byte_sel ? {{(W-H){1'b0}}, dst[H-1], dst[H-1:1]}
                                   : {dst[W-1], dst[W-1:1]};
      OP_SWPB:        r = {dst[H-1:0], dst[W-1:H]};
      OP_SXT:         r = {{(W-H){dst[H-1]}}, dst[H-1:0]};
      default:        r = '0;
    endcase
    if (byte_sel && !word_only) res = {{(W-H){1'b0}}, r[H-1:0]};
    else                        res = r;
  end
endmodule

// File: rtl/bw_alu.sv
// Top: selects the path, builds the flags and mask, registers the outcome.
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [3:0]     op,
  input  logic           byte_sel,
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   dst,
  input  logic           carry_in,
  output logic           out_valid,
  output logic [W-1:0]   result,
  output logic           wr_en,
  output logic [3:0]     flag_we,
  output logic           flag_v,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_c
);
  localparam int H = W / 2;

  alu_op_e      op_e;
  logic [1:0]   rst_pipe;
  logic         rst_int_n;
  logic [W-1:0] ar_sum, bcd_sum, lg_res;
  logic         ar_cout, ar_ovf, bcd_cout, lg_shout;

  logic [W-1:0]    nx_res;
  logic            nx_wr, nx_c, nx_v, nx_n, nx_z, narrow;
  logic [FL_W-1:0] nx_mask;
  logic [FL_W-1:0] nx_flags;

  assign op_e = alu_op_e'(op);

  // Reset asserts at once, releases two clocks after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  bwa_arith #(.W(W)) u_arith (
    .op(op_e), .byte_sel(byte_sel), .src(src), .dst(dst), .cin(carry_in),
    .sum(ar_sum), .cout(ar_cout), .ovf(ar_ovf)
  );

  bwa_bcd #(.W(W)) u_bcd (
    .byte_sel(byte_sel), .src(src), .dst(dst), .cin(carry_in),
    .sum(bcd_sum), .cout(bcd_cout)
  );

  bwa_logic #(.W(W)) u_logic (
    .op(op_e), .byte_sel(byte_sel), .src(src), .dst(dst), .cin(carry_in),
    .res(lg_res), .shout(lg_shout)
  );

  always_comb begin
    narrow  = byte_sel && (op_e != OP_SWPB) && (op_e != OP_SXT);
    nx_wr   = (op_e != OP_CMP) && (op_e != OP_BIT);
    nx_mask = FLAGS_ALL;
    nx_c    = 1'b0;
    nx_v    = 1'b0;
    case (op_e)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: nx_res = ar_sum;
      OP_DADD:                                   nx_res = bcd_sum;
      default:                                   nx_res = lg_res;
    endcase
    nx_n = narrow ? nx_res[H-1] : nx_res[W-1];
    nx_z = narrow ? (nx_res[H-1:0] == '0) : (nx_res == '0);
    case (op_e)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        nx_c = ar_cout;
        nx_v = ar_ovf;
      end
      OP_DADD:                nx_c = bcd_cout;
      OP_AND, OP_BIT, OP_SXT: nx_c = !nx_z;
      OP_XOR: begin
        nx_c = !nx_z;
        nx_v = narrow ? (src[H-1] & dst[H-1]) : (src[W-1] & dst[W-1]);
      end
      OP_RRC, OP_RRA:         nx_c = lg_shout;
      default:                nx_mask = FLAGS_NONE;
    endcase
    nx_flags = {nx_v, nx_n, nx_z, nx_c} & nx_mask;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      flag_we   <= '0;
      {flag_v, flag_n, flag_z, flag_c} <= '0;
    end else begin
      out_valid <= issue;
      if (issue) begin
        result    <= nx_res;
        wr_en     <= nx_wr;
        flag_we   <= nx_mask;
        {flag_v, flag_n, flag_z, flag_c} <= nx_flags;
      end
    end
  end
endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue,
  input logic [3:0]   op,
  input logic         byte_sel,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   flag_we,
  input logic         flag_z
);
  localparam int H = W / 2;

  // R11: valid follows issue by exactly one clock
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(issue));

  // R7: compare and bit-test never request write-back
  p_no_writeback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (op == 4'd4 || op == 4'd10)) |=> !wr_en);

  // R6: byte operations clear the upper byte
  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && byte_sel && op != 4'd14 && op != 4'd15) |=> result[W-1:H] == '0);

  // R8: Z agrees with the registered result at the active width
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_we[1]) |->
      flag_z == ($past(byte_sel && op != 4'd15) ? (result[H-1:0] == '0) : (result == '0)));

  // R10: move and byte exchange update no flag
  p_no_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (op == 4'd11 || op == 4'd14)) |=> flag_we == 4'h0);

  // R11: no issue, no change of the result
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(result));
endmodule

bind bw_alu bw_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .byte_sel(byte_sel),
  .out_valid(out_valid), .result(result), .wr_en(wr_en), .flag_we(flag_we),
  .flag_z(flag_z)
);

// File: tb/sim_bw_alu.sv
`timescale 1ns/1ps
module sim_bw_alu;
  localparam logic [3:0] K_ADD=0, K_ADDC=1, K_SUB=2, K_SUBC=3, K_CMP=4, K_DADD=5,
    K_AND=6, K_BIC=7, K_BIS=8, K_XOR=9, K_BIT=10, K_MOV=11, K_RRC=12, K_RRA=13,
    K_SWPB=14, K_SXT=15;

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [3:0]  mask;
    logic [3:0]  fl;   // {V,N,Z,C}
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  op = '0;
  logic        byte_sel = 1'b0;
  logic [15:0] src = '0, dst = '0;
  logic        carry_in = 1'b0;
  logic        out_valid, wr_en, flag_v, flag_n, flag_z, flag_c;
  logic [15:0] result;
  logic [3:0]  flag_we;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  bw_alu #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .byte_sel(byte_sel),
    .src(src), .dst(dst), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .flag_we(flag_we), .flag_v(flag_v),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  function automatic int sx(int x, int w);
    return (x >> (w-1)) & 1 ? x - (1 << w) : x;
  endfunction

  function automatic int bcd_val(int x, int nd);
    int v = 0, m = 1;
    for (int k = 0; k < nd; k++) begin v += ((x >> (4*k)) & 15) * m; m *= 10; end
    return v;
  endfunction

  function automatic int bcd_enc(int v, int nd);
    int x = 0;
    for (int k = 0; k < nd; k++) begin x |= (v % 10) << (4*k); v /= 10; end
    return x;
  endfunction

  function automatic exp_t model(logic [3:0] o, bit bm, logic [15:0] s, logic [15:0] d,
                                 bit ci, string tag);
    exp_t e;
    int w, msk, sgn, a, b, r, t, tv, c, v, lim;
    bit wide_only;
    wide_only = (o == K_SWPB) || (o == K_SXT);
    w   = (bm && !wide_only) ? 8 : 16;
    msk = (1 << w) - 1;
    sgn = 1 << (w-1);
    a = int'(d) & msk;
    b = int'(s) & msk;
    c = 0; v = 0;
    e.mask = 4'hF;
    case (o)
      K_ADD, K_ADDC: begin
        t  = a + b + ((o == K_ADDC) ? int'(ci) : 0);
        tv = sx(a, w) + sx(b, w) + ((o == K_ADDC) ? int'(ci) : 0);
        r = t & msk; c = (t >> w) & 1;
        v = (tv > sgn - 1 || tv < -sgn) ? 1 : 0;
      end
      K_SUB, K_SUBC, K_CMP: begin
        int ce;
        ce = (o == K_SUBC) ? int'(ci) : 1;
        t  = a + ((~b) & msk) + ce;
        tv = sx(a, w) - sx(b, w) - 1 + ce;
        r = t & msk; c = (t >> w) & 1;
        v = (tv > sgn - 1 || tv < -sgn) ? 1 : 0;
      end
      K_DADD: begin
        int nd;
        nd = w / 4; lim = 1;
        for (int k = 0; k < nd; k++) lim *= 10;
        t = bcd_val(a, nd) + bcd_val(b, nd) + int'(ci);
        c = (t >= lim) ? 1 : 0;
        r = bcd_enc(t % lim, nd);
      end
      K_AND, K_BIT: begin r = a & b; c = (r != 0); end
      K_XOR: begin r = a ^ b; c = (r != 0); v = ((a & sgn) != 0) && ((b & sgn) != 0); end
      K_BIC: begin r = (~b) & a & msk; e.mask = 0; end
      K_BIS: begin r = a | b; e.mask = 0; end
      K_MOV: begin r = b; e.mask = 0; end
      K_RRC: begin r = (a >> 1) | (ci ? sgn : 0); c = a & 1; end
      K_RRA: begin r = (a >> 1) | (a & sgn); c = a & 1; end
      K_SWPB: begin r = ((a & 255) << 8) | (a >> 8); e.mask = 0; end
      default: begin r = (a & 128) ? ((a & 255) | 16'hFF00) : (a & 255); c = (r != 0); end
    endcase
    e.res = r[15:0];
    e.we  = !((o == K_CMP) || (o == K_BIT));
    e.fl  = {v[0], ((r & sgn) != 0), (r == 0), c[0]} & e.mask;
    e.tag = tag;
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] o, bit bm, logic [15:0] s, logic [15:0] d, bit ci,
                       string tag);
    @(negedge clk);
    op = o; byte_sel = bm; src = s; dst = d; carry_in = ci; issue = 1'b1;
    sb.push_back(model(o, bm, s, d, ci, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    issue = 1'b0;
  endtask

  // Monitor: compare each registered result against the queued expectation.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11", "unexpected valid", 32'(out_valid), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.res, e.tag, "result", 32'(result), 32'(e.res));
        check(wr_en == e.we && flag_we == e.mask, e.tag, "we/mask",
              {27'd0, wr_en, flag_we}, {27'd0, e.we, e.mask});
        check({flag_v, flag_n, flag_z, flag_c} == e.fl, e.tag, "flags {V,N,Z,C}",
              32'({flag_v, flag_n, flag_z, flag_c}), 32'(e.fl));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid == 0 && result == 0 && wr_en == 0 && flag_we == 0 &&
          {flag_v, flag_n, flag_z, flag_c} == 0, "R11", "reset outputs",
          32'(result), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R9 arithmetic and flags
    drive(K_ADD,  0, 16'h4321, 16'h1234, 0, "R1");
    drive(K_ADD,  0, 16'h0001, 16'hFFFF, 0, "R9");
    drive(K_ADD,  0, 16'h0001, 16'h7FFF, 0, "R9");
    drive(K_ADD,  1, 16'hAA01, 16'h557F, 0, "R6");
    drive(K_ADDC, 0, 16'h0001, 16'h0001, 1, "R1");
    drive(K_SUB,  0, 16'h0003, 16'h0005, 0, "R9");
    drive(K_SUB,  0, 16'h0005, 16'h0003, 0, "R9");
    drive(K_SUB,  1, 16'h0001, 16'h0080, 0, "R9");
    drive(K_SUBC, 0, 16'h0001, 16'h0010, 0, "R1");
    drive(K_SUBC, 0, 16'h0001, 16'h0010, 1, "R1");
    drive(K_CMP,  0, 16'h1234, 16'h1234, 0, "R7");
    // R3 decimal add
    drive(K_DADD, 1, 16'h0001, 16'h0099, 0, "R3");
    drive(K_DADD, 0, 16'h5678, 16'h1234, 1, "R3");
    drive(K_DADD, 0, 16'h0001, 16'h9999, 0, "R3");
    drive(K_DADD, 1, 16'hAB45, 16'hCD38, 0, "R3");
    // R2 bitwise
    drive(K_AND, 0, 16'hF0F0, 16'h0F0F, 0, "R2");
    drive(K_BIC, 0, 16'h00FF, 16'h1234, 1, "R2");
    drive(K_BIS, 0, 16'h8000, 16'h0001, 0, "R2");
    drive(K_XOR, 0, 16'h8001, 16'h8100, 0, "R10");
    drive(K_XOR, 1, 16'h0080, 16'h0081, 0, "R10");
    drive(K_BIT, 0, 16'h0010, 16'h0030, 0, "R7");
    drive(K_MOV, 1, 16'hFF80, 16'h1234, 1, "R6");
    // R4 shifts
    drive(K_RRC, 0, 16'h0000, 16'h0003, 1, "R4");
    drive(K_RRC, 1, 16'h0000, 16'h0F02, 1, "R4");
    drive(K_RRA, 0, 16'h0000, 16'h8004, 0, "R4");
    drive(K_RRA, 1, 16'h0000, 16'h0081, 0, "R4");
    // R5 byte exchange and sign extension ignore byte_sel
    drive(K_SWPB, 1, 16'h0000, 16'h12AB, 0, "R5");
    drive(K_SXT,  1, 16'h0000, 16'h1280, 0, "R5");
    drive(K_SXT,  0, 16'h0000, 16'hFF00, 0, "R8");
    // Mixed patterns
    for (int i = 0; i < 200; i++) begin
      logic [3:0] o;
      logic [15:0] s, d;
      o = 4'($urandom % 16);
      s = 16'($urandom); d = 16'($urandom);
      if (o == K_DADD) begin
        for (int k = 0; k < 4; k++) begin
          s[4*k +: 4] = 4'($urandom % 10);
          d[4*k +: 4] = 4'($urandom % 10);
        end
      end
      drive(o, 1'($urandom), s, d, 1'($urandom), "R10");
    end
    idle();
    repeat (2) @(negedge clk);

    // R11: outputs hold while no operation is issued
    held = result;
    src = 16'hFFFF; dst = 16'hFFFF; op = K_ADD;
    repeat (3) @(negedge clk);
    check(result == held && out_valid == 0, "R11", "hold", 32'(result), 32'(held));
    check(sb.size() == 0, "R11", "pending results", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule